// File: doc/BRIEF.md
# Deciphered Bitstream Preamble Gate

This block sits between a deciphering engine and the fabric configuration logic. It receives the already-deciphered bitstream as 128-bit words. A three-word preamble must be valid before any payload is passed on. The first word is a rollback counter. It is compared with a stored anti-rollback value, and the current lifecycle input selects the comparison rule. The second word must match a fixed tag constant. The third word gives the payload length in 32-bit words, and that length includes the padding.

Once the preamble is accepted, each 128-bit payload word is split into four 32-bit words, most-significant first. They leave through a valid/ready handshake. A separate 2-bit input says how many trailing 32-bit words are padding. Those words are dropped, and the last flag marks the final real word. If any check fails, the block latches an error code and drops all later input until reset. If every real word is delivered, a pass flag rises.

Top module: `preamble_gate`

## Requirements
- R1: After reset, `outValid` is low, `errCode` is 0, `passed` is low and `inReady` is high.
- R2: The input words are read in a fixed order: rollback counter, then tag, then size. Only words after these three are treated as payload.
- R3: The tag word must equal 128'h2e900db007ab7eacce55c0dede7ec7ed. Any other value sets `errCode` to 1.
- R4: For lifecycle codes 4 and 7 (space grade), the counter must be strictly greater than `storedCtr`. For codes 0, 1, 2, 3, 5 and 6, the two must be equal. A mismatch sets `errCode` to 2.
- R5: Lifecycle code 8 (end of life) and the unused codes 9 to 15 refuse the load on the first word, whatever the counter value. They set `errCode` to 3.
- R6: The size word must be nonzero, a multiple of four, and below 2^CNT_W. Otherwise `errCode` becomes 4.
- R7: Each 128-bit payload word is emitted as four 32-bit words: bits [127:96] first, then [95:64], then [63:32], then [31:0].
- R8: Exactly size minus `padCount` words are emitted. `padCount` is sampled when the size word is accepted. `outLast` is high only on the final emitted word.
- R9: While `outValid` is high and `outReady` is low, `outData` and `outLast` hold their values and no new input word is accepted.
- R10: After an error, `errCode` stays fixed, `outValid` stays low, and `inReady` is high so that further input is accepted and dropped.
- R11: After the final real word has been transferred, `passed` goes high with `errCode` 0 and stays high. Later input is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lifeCycle | input | 4 | Encoded lifecycle stage |
| storedCtr | input | IN_W | Stored anti-rollback counter |
| padCount | input | LANE_W | Number of trailing padding words |
| inValid | input | 1 | Input word valid |
| inData | input | IN_W | Deciphered 128-bit input word |
| inReady | output | 1 | Input word accepted when high with `inValid` |
| outValid | output | 1 | Output word valid |
| outData | output | OUT_W | 32-bit payload word |
| outLast | output | 1 | Final real payload word |
| outReady | input | 1 | Downstream ready |
| errCode | output | 3 | Sticky error: 0 none, 1 tag, 2 rollback, 3 lifecycle, 4 size |
| passed | output | 1 | Load completed successfully |

## Verification
The embedded properties check several behaviours on every cycle. Output words hold steady under backpressure. A buffered word is never overwritten before it drains. The failure state and its error code are sticky, and no output is presented once an error exists. The pass flag stays high and error-free. Only the directed scenarios can show the rest: the lifecycle-specific rollback rules with counters that differ in their upper bits, the tag and size rejections, the most-significant-first lane order, and the exact number of words kept for each padding count together with the placement of the last flag.

// File: rtl/preamble_gate_pkg.sv
package preamble_gate_pkg;

  localparam logic [127:0] TAG_CONST = 128'h2e900db007ab7eacce55c0dede7ec7ed;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_TAG      = 3'd1,
    ERR_ROLLBACK = 3'd2,
    ERR_LIFE     = 3'd3,
    ERR_SIZE     = 3'd4
  } errCode_e;

  typedef enum logic [1:0] {
    RULE_EQUAL,
    RULE_GREATER,
    RULE_DENY
  } ctrRule_e;

  typedef struct packed {
    logic loadSize;
    logic loadWord;
  } dpStrobe_t;

  // Lifecycle codes: 0..3, 5, 6 need equality; 4 and 7 are space grade;
  // 8 is end of life and 9..15 are unused.
  function automatic ctrRule_e ruleOf(input logic [3:0] lc);
    case (lc)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd6: ruleOf = RULE_EQUAL;
      4'd4, 4'd7:                         ruleOf = RULE_GREATER;
      default:                            ruleOf = RULE_DENY;
    endcase
  endfunction

endpackage

// File: rtl/preamble_gate_ctrl.sv
module preamble_gate_ctrl
  import preamble_gate_pkg::*;
#(
  parameter int IN_W   = 128,
  parameter int CNT_W  = 32,
  parameter int LANE_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [3:0]      lifeCycle,
  input  logic [IN_W-1:0] storedCtr,
  input  logic            inValid,
  input  logic [IN_W-1:0] inData,
  input  logic            bufFull,
  input  logic            lastXfer,
  output logic            inReady,
  output dpStrobe_t       strobe,
  output logic [2:0]      errCode,
  output logic            passed
);

  typedef enum logic [2:0] {
    ST_CTR, ST_TAG, ST_SIZE, ST_BODY, ST_DONE, ST_FAIL
  } state_e;

  state_e   state, nextState;
  errCode_e errReg, nextErr;
  logic     accept;
  logic     sizeOk;
  ctrRule_e rule;

  assign inReady = (state == ST_BODY) ? !bufFull : 1'b1;
  assign accept  = inValid && inReady;
  assign rule    = ruleOf(lifeCycle);
  assign sizeOk  = (inData[LANE_W-1:0] == '0) &&
                   (inData[CNT_W-1:0] != '0) &&
                   (inData[IN_W-1:CNT_W] == '0);

  always_comb begin
    nextState = state;
    nextErr   = errReg;
    strobe    = '0;
    case (state)
      ST_CTR: if (accept) begin
        if (rule == RULE_DENY) begin
          nextState = ST_FAIL;
          nextErr   = ERR_LIFE;
        end else if ((rule == RULE_GREATER) ? (inData > storedCtr)
                                            : (inData == storedCtr)) begin
          nextState = ST_TAG;
        end else begin
          nextState = ST_FAIL;
          nextErr   = ERR_ROLLBACK;
        end
      end
      ST_TAG: if (accept) begin
        if (inData == IN_W'(TAG_CONST)) nextState = ST_SIZE;
        else begin
          nextState = ST_FAIL;
          nextErr   = ERR_TAG;
        end
      end
      ST_SIZE: if (accept) begin
        if (sizeOk) begin
          nextState       = ST_BODY;
          strobe.loadSize = 1'b1;
        end else begin
          nextState = ST_FAIL;
          nextErr   = ERR_SIZE;
        end
      end
      ST_BODY: begin
        if (accept)   strobe.loadWord = 1'b1;
        if (lastXfer) nextState = ST_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_CTR;
      errReg <= ERR_NONE;
    end else begin
      state  <= nextState;
      errReg <= nextErr;
    end
  end

  assign errCode = errReg;
  assign passed  = (state == ST_DONE);

  // R10
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAIL) |=> (state == ST_FAIL) && $stable(errCode));

endmodule

// File: rtl/preamble_gate_dp.sv
module preamble_gate_dp
  import preamble_gate_pkg::*;
#(
  parameter int IN_W  = 128,
  parameter int OUT_W = 32,
  parameter int CNT_W = 32,
  localparam int LANES  = IN_W / OUT_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IN_W-1:0]   inData,
  input  logic [LANE_W-1:0] padCount,
  input  logic              outReady,
  output logic              bufFull,
  output logic              outValid,
  output logic [OUT_W-1:0]  outData,
  output logic              outLast,
  output logic              lastXfer
);

  logic [IN_W-1:0]   wordReg;
  logic [LANE_W-1:0] laneIdx;
  logic [CNT_W-1:0]  realLeft;
  logic [OUT_W-1:0]  laneWord [LANES];
  logic              xfer;
  logic              finalWord;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneWord[i] = wordReg[IN_W-1-i*OUT_W -: OUT_W];
  end

  assign finalWord = (realLeft == CNT_W'(1));
  assign xfer      = bufFull && outReady;
  assign lastXfer  = xfer && finalWord;
  assign outValid  = bufFull;
  assign outData   = laneWord[laneIdx];
  assign outLast   = bufFull && finalWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg  <= '0;
      laneIdx  <= '0;
      realLeft <= '0;
      bufFull  <= 1'b0;
    end else begin
      if (strobe.loadSize)
        realLeft <= inData[CNT_W-1:0] - CNT_W'(padCount);
      if (strobe.loadWord) begin
        wordReg <= inData;
        laneIdx <= '0;
        bufFull <= 1'b1;
      end else if (xfer) begin
        laneIdx  <= laneIdx + 1'b1;
        realLeft <= realLeft - 1'b1;
        if (finalWord || laneIdx == LANE_W'(LANES - 1)) bufFull <= 1'b0;
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outData) && $stable(outLast));

  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadWord && bufFull));

endmodule

// File: rtl/preamble_gate.sv
module preamble_gate
  import preamble_gate_pkg::*;
#(
  parameter int IN_W  = 128,
  parameter int OUT_W = 32,
  parameter int CNT_W = 32,
  localparam int LANE_W = $clog2(IN_W / OUT_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        lifeCycle,
  input  logic [IN_W-1:0]   storedCtr,
  input  logic [LANE_W-1:0] padCount,
  input  logic              inValid,
  input  logic [IN_W-1:0]   inData,
  output logic              inReady,
  output logic              outValid,
  output logic [OUT_W-1:0]  outData,
  output logic              outLast,
  input  logic              outReady,
  output logic [2:0]        errCode,
  output logic              passed
);

  dpStrobe_t strobe;
  logic      bufFull;
  logic      lastXfer;

  preamble_gate_ctrl #(.IN_W(IN_W), .CNT_W(CNT_W), .LANE_W(LANE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lifeCycle(lifeCycle), .storedCtr(storedCtr),
    .inValid(inValid), .inData(inData), .bufFull(bufFull), .lastXfer(lastXfer),
    .inReady(inReady), .strobe(strobe), .errCode(errCode), .passed(passed)
  );

  preamble_gate_dp #(.IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .padCount(padCount), .outReady(outReady), .bufFull(bufFull),
    .outValid(outValid), .outData(outData), .outLast(outLast),
    .lastXfer(lastXfer)
  );

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != 3'd0) |-> !outValid);

  // R11
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    passed |=> passed && (errCode == 3'd0));

endmodule

// File: tb/test_preamble_gate.sv
module test_preamble_gate;

  localparam logic [127:0] TAG = 128'h2e900db007ab7eacce55c0dede7ec7ed;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   lifeCycle = 4'd0;
  logic [127:0] storedCtr = '0;
  logic [1:0]   padCount = 2'd0;
  logic         inValid = 1'b0;
  logic [127:0] inData = '0;
  logic         inReady;
  logic         outValid;
  logic [31:0]  outData;
  logic         outLast;
  logic         outReady = 1'b1;
  logic [2:0]   errCode;
  logic         passed;

  int checks = 0;
  int fails = 0;
  int gotN = 0;
  int cyc = 0;
  bit bpMode = 1'b0;
  logic [31:0] gotData [0:63];
  bit          gotLast [0:63];

  preamble_gate i_preamble_gate (
    .clk(clk), .rstN(rstN), .lifeCycle(lifeCycle), .storedCtr(storedCtr),
    .padCount(padCount), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outLast(outLast),
    .outReady(outReady), .errCode(errCode), .passed(passed)
  );

  always #5 clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      outReady = bpMode ? ((cyc % 3) != 0) : 1'b1;
      if (cyc > 20000) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected<=20000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rstN && outValid && outReady && gotN < 64) begin
        gotData[gotN] = outData;
        gotLast[gotN] = outLast;
        gotN++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    gotN = 0;
  endtask

  task automatic send_word(input logic [127:0] w);
    inValid = 1'b1;
    inData = w;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] seed, input int k);
    return seed ^ (32'(k) * 32'h9e3779b9);
  endfunction

  task automatic test_reset_state();
    do_reset();
    @(negedge clk);
    check(!outValid, "R1", "outValid", 128'(outValid), 0);
    check(errCode == 0, "R1", "errCode", 128'(errCode), 0);
    check(!passed, "R1", "passed", 128'(passed), 0);
    check(inReady, "R1", "inReady", 128'(inReady), 1);
  endtask

  // Passing load: nWords real words followed by pad padding words.
  task automatic test_payload(input logic [3:0] lc, input logic [127:0] stored,
                              input logic [127:0] ctr, input int pad,
                              input int nWords, input logic [31:0] seed,
                              input bit bp);
    int total;
    total = nWords + pad;
    do_reset();
    lifeCycle = lc;
    storedCtr = stored;
    padCount = 2'(pad);
    bpMode = bp;
    send_word(ctr);                   // R2 counter first
    send_word(TAG);
    send_word(128'(total));
    for (int j = 0; j < total / 4; j++) begin
      logic [127:0] w;
      for (int i = 0; i < 4; i++) begin
        int k;
        k = j * 4 + i;
        w[127 - i*32 -: 32] = (k < nWords) ? exp_word(seed, k) : (32'hdead0000 + 32'(k));
      end
      send_word(w);
    end
    repeat (30) @(negedge clk);
    check(errCode == 0, "R4", "errCode on accepted load", 128'(errCode), 0);
    check(gotN == nWords, "R8", "emitted word count", 128'(gotN), 128'(nWords));
    for (int k = 0; k < nWords && k < gotN; k++) begin
      check(gotData[k] == exp_word(seed, k), "R7", $sformatf("word %0d", k),
            128'(gotData[k]), 128'(exp_word(seed, k)));
      check(gotLast[k] == (k == nWords - 1), "R8", $sformatf("last flag %0d", k),
            128'(gotLast[k]), 128'(k == nWords - 1));
    end
    check(passed, "R11", "passed", 128'(passed), 1);
    send_word(128'h1234);
    repeat (5) @(negedge clk);
    check(gotN == nWords && passed && inReady, "R11", "input after pass dropped",
          128'(gotN), 128'(nWords));
    bpMode = 1'b0;
  endtask

  // Failing load: full preamble and one body word, then sticky error checks.
  task automatic test_fail(input logic [3:0] lc, input logic [127:0] stored,
                           input logic [127:0] ctr, input logic [127:0] tag,
                           input logic [127:0] size, input logic [2:0] expErr,
                           input string req);
    do_reset();
    lifeCycle = lc;
    storedCtr = stored;
    padCount = 2'd0;
    send_word(ctr);
    send_word(tag);
    send_word(size);
    send_word(128'hffff_eeee_dddd_cccc_bbbb_aaaa_9999_8888);
    repeat (5) @(negedge clk);
    check(errCode == expErr, req, "error code", 128'(errCode), 128'(expErr));
    check(gotN == 0 && !outValid, "R10", "no output after error", 128'(gotN), 0);
    check(inReady && !passed, "R10", "input dropped, not passed",
          128'({inReady, passed}), 128'(2'b10));
  endtask

  localparam logic [127:0] BIGCTR = 128'h0000_0001_0000_0000_0000_0000_0000_0005;

  initial begin
    test_reset_state();
    // R7 R8: pad 1, equal rule, no backpressure
    test_payload(4'd2, BIGCTR, BIGCTR, 1, 7, 32'h1357_9bdf, 1'b0);
    // R9: pad 0 with backpressure
    test_payload(4'd5, 128'd9, 128'd9, 0, 8, 32'h0f0f_a5a5, 1'b1);
    // R8: pad 3, single real word
    test_payload(4'd0, 128'd0, 128'd0, 3, 1, 32'hcafe_0001, 1'b1);
    // R8: pad 2
    test_payload(4'd6, 128'd3, 128'd3, 2, 6, 32'h2468_ace0, 1'b0);
    // R4: space grade, counter greater in upper bits
    test_payload(4'd4, BIGCTR, BIGCTR + (128'd1 << 100), 0, 4, 32'h7777_0000, 1'b0);
    test_payload(4'd7, 128'd5, 128'd6, 1, 3, 32'h5555_1111, 1'b1);
    // R4: space grade with equal counter fails
    test_fail(4'd7, BIGCTR, BIGCTR, TAG, 128'd4, 3'd2, "R4");
    // R4: equal rule with greater counter fails
    test_fail(4'd3, 128'd5, 128'd5 + (128'd1 << 64), TAG, 128'd4, 3'd2, "R4");
    // R5: end of life and unused code refuse
    test_fail(4'd8, 128'd0, 128'd0, TAG, 128'd4, 3'd3, "R5");
    test_fail(4'd11, 128'd0, 128'd1, TAG, 128'd4, 3'd3, "R5");
    // R3: corrupted tag
    test_fail(4'd1, 128'd0, 128'd0, TAG ^ 128'd1, 128'd4, 3'd1, "R3");
    // R6: bad sizes
    test_fail(4'd1, 128'd0, 128'd0, TAG, 128'd0, 3'd4, "R6");
    test_fail(4'd1, 128'd0, 128'd0, TAG, 128'd6, 3'd4, "R6");
    test_fail(4'd1, 128'd0, 128'd0, TAG, (128'd1 << 40) | 128'd4, 3'd4, "R6");
    finish_run();
  end

endmodule